// File: doc/BRIEF.md
# GPIO Register Bank with Atomic Bit Aliases

This block holds the software-visible state of a multi-port general-purpose I/O controller. Each port is 32 bits wide and each bit belongs to one pin. Software reaches the block through a plain synchronous register bus made of an address, a write strobe, write data, a read strobe and registered read data.

Per port, the bank holds:
- the output level;
- the pin direction;
- four interrupt configuration words: enable, polarity, trigger type and async select;
- a sticky interrupt flag word, which is cleared by writing 1s to it.

Each writable word can be changed in four ways: a plain write, or an atomic OR, AND-NOT or XOR. Each of these is reached at its own alias address, so software can change single bits without a read-modify-write sequence. The pin inputs are synchronised to the clock and can be read back as a read-only word.

The block drives the pin output and output-enable vectors. It also exports the configuration vectors to an interrupt detector that sits outside the block. That detector sets the flag bits through a set vector.

Top module: `gpio_regbank`

## Requirements
- R1: After rst_ni is asserted, every register is zero. This means pin_oe_o, pin_out_o, irq_flag_o and all four configuration exports are zero, and every readable word reads 0.
- R2: Byte address bits [11:8] select the group: 0 input, 1 output level, 2 direction, 3 flag, 4 enable, 5 polarity, 6 type, 7 async. Bits [7:4] select the port, bits [3:2] select the alias (0 value, 1 set, 2 clear, 3 toggle), and bits [1:0] are ignored.
- R3: In groups 1, 2, 4, 5, 6 and 7, each alias acts on the register as follows:
  - value: the written word replaces the register;
  - set: the written word is ORed in;
  - clear: the written 1-bits are cleared;
  - toggle: the written 1-bits are inverted.
  Words that are not written keep their value.
- R4: A read of any alias of groups 1, 2, 4, 5, 6 and 7 returns the register's current value.
- R5: A read strobe sampled at one clock edge makes bus_rvalid_o high and bus_rdata_o valid after that same edge. A read and a write to the same word in one cycle return the value from before the write.
- R6: pin_oe_o equals the direction registers (1 = output). pin_out_o carries an output-level bit only where its direction bit is 1, and is 0 elsewhere.
- R7: Pin inputs pass through two flops. A pin change made before clock edge k is returned by a read sampled at edge k+2, and not by reads sampled at edges k or k+1.
- R8: Groups 0 and 3 have only alias 0. Their aliases 1 to 3 read 0 and ignore writes, and writes to group 0 are ignored.
- R9: A 1 on flag_set_i sets the matching flag bit at the next edge, and the bit stays set. Writing group 3 alias 0 clears the flag bits written as 1. If a set and a clear hit the same bit in the same cycle, the set wins.
- R10: Groups 8 to 15 and port slots at or above NUM_PORTS read 0 and ignore writes.
- R11: Port p's enable, polarity, type and async registers appear on bits [32p+31:32p] of irq_en_o, irq_pol_o, irq_type_o and irq_async_o. pin_out_o, pin_oe_o and irq_flag_o use the same bit layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 12 | Byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | DATA_W | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid |
| pin_in_i | input | NUM_PORTS*DATA_W | Pin levels (asynchronous) |
| pin_out_o | output | NUM_PORTS*DATA_W | Pin drive levels, gated by direction |
| pin_oe_o | output | NUM_PORTS*DATA_W | Pin output enables |
| flag_set_i | input | NUM_PORTS*DATA_W | Interrupt flag set requests |
| irq_flag_o | output | NUM_PORTS*DATA_W | Interrupt flags |
| irq_en_o | output | NUM_PORTS*DATA_W | Interrupt enables |
| irq_pol_o | output | NUM_PORTS*DATA_W | Interrupt polarity |
| irq_type_o | output | NUM_PORTS*DATA_W | Interrupt trigger type |
| irq_async_o | output | NUM_PORTS*DATA_W | Interrupt async select |

## Verification
The bench runs a chain of set, clear and toggle writes on one word and checks each result against a hand-computed value. An alias decoded to the wrong operation, or a wrong port or group selected, therefore gives a wrong word.

Three back-to-back reads around a pin change show the synchronizer depth: with one flop too few or too many, the new level appears a read early or a read late.

A flag clear is issued in the same cycle as a hardware set. If clear has priority, a real event is lost, and the bench sees the bit read back as 0.

The bench writes to reserved aliases, unimplemented ports and groups 8 to 15, and checks both the read-back and the exported vectors. A design that aliased these addresses onto real registers would corrupt live state.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;
  typedef enum logic [1:0] {OP_VAL = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_TGL = 2'd3} alias_op_e;

  localparam int unsigned NUM_GRP = 8;
  localparam logic [3:0] G_IN   = 4'd0;
  localparam logic [3:0] G_OUT  = 4'd1;
  localparam logic [3:0] G_DIR  = 4'd2;
  localparam logic [3:0] G_FLAG = 4'd3;
  localparam logic [3:0] G_EN   = 4'd4;
  localparam logic [3:0] G_POL  = 4'd5;
  localparam logic [3:0] G_TYPE = 4'd6;
  localparam logic [3:0] G_ASYN = 4'd7;

  typedef struct packed {
    logic      hit;
    logic [3:0] grp;
    logic [3:0] port;
    alias_op_e op;
  } dec_t;
endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
  import gpio_rb_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [11:0] addr_i,
  output dec_t        dec_o
);
  logic single_word;

  always_comb begin
    dec_o.grp   = addr_i[11:8];
    dec_o.port  = addr_i[7:4];
    dec_o.op    = alias_op_e'(addr_i[3:2]);
    single_word = (dec_o.grp == G_IN) || (dec_o.grp == G_FLAG);
    dec_o.hit   = (dec_o.grp < 4'(NUM_GRP)) && (32'(dec_o.port) < NUM_PORTS)
                  && (!single_word || dec_o.op == OP_VAL);
  end
endmodule

// File: rtl/gpio_rb_alias_reg.sv
module gpio_rb_alias_reg
  import gpio_rb_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  always_comb begin
    unique case (op_i)
      OP_VAL:  nxt = wdata_i;
      OP_SET:  nxt = q_o | wdata_i;
      OP_CLR:  nxt = q_o & ~wdata_i;
      default: nxt = q_o ^ wdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= nxt;
  end
endmodule

// File: rtl/gpio_rb_flag_reg.sv
module gpio_rb_flag_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] clr_mask;
  assign clr_mask = clr_en_i ? wdata_i : '0;

  // set dominates so no hardware event is lost to a racing clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_mask) | set_i;
  end
endmodule

// File: rtl/gpio_rb_sync.sv
module gpio_rb_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_rb_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [11:0]                   bus_addr_i,
  input  logic                          bus_we_i,
  input  logic [DATA_W-1:0]             bus_wdata_i,
  input  logic                          bus_re_i,
  output logic [DATA_W-1:0]             bus_rdata_o,
  output logic                          bus_rvalid_o,
  input  logic [NUM_PORTS*DATA_W-1:0]   pin_in_i,
  output logic [NUM_PORTS*DATA_W-1:0]   pin_out_o,
  output logic [NUM_PORTS*DATA_W-1:0]   pin_oe_o,
  input  logic [NUM_PORTS*DATA_W-1:0]   flag_set_i,
  output logic [NUM_PORTS*DATA_W-1:0]   irq_flag_o,
  output logic [NUM_PORTS*DATA_W-1:0]   irq_en_o,
  output logic [NUM_PORTS*DATA_W-1:0]   irq_pol_o,
  output logic [NUM_PORTS*DATA_W-1:0]   irq_type_o,
  output logic [NUM_PORTS*DATA_W-1:0]   irq_async_o
);
  localparam int unsigned VEC_W = NUM_PORTS * DATA_W;

  dec_t              dec;
  logic [VEC_W-1:0]  pin_sync;
  logic [DATA_W-1:0] grp_q [NUM_GRP][NUM_PORTS];
  logic [DATA_W-1:0] rd_val;

  gpio_rb_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
    .addr_i (bus_addr_i),
    .dec_o  (dec)
  );

  gpio_rb_sync #(.W(VEC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic port_wr;
    assign port_wr = bus_we_i && dec.hit && (32'(dec.port) == p);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      if (g == int'(G_IN)) begin : g_in
        assign grp_q[g][p] = pin_sync[p*DATA_W +: DATA_W];
      end else if (g == int'(G_FLAG)) begin : g_flag
        gpio_rb_flag_reg #(.W(DATA_W)) u_flag (
          .clk_i    (clk_i),
          .rst_ni   (rst_ni),
          .set_i    (flag_set_i[p*DATA_W +: DATA_W]),
          .clr_en_i (port_wr && dec.grp == G_FLAG),
          .wdata_i  (bus_wdata_i),
          .q_o      (grp_q[g][p])
        );
      end else begin : g_cfg
        gpio_rb_alias_reg #(.W(DATA_W)) u_reg (
          .clk_i   (clk_i),
          .rst_ni  (rst_ni),
          .wr_en_i (port_wr && dec.grp == 4'(g)),
          .op_i    (dec.op),
          .wdata_i (bus_wdata_i),
          .q_o     (grp_q[g][p])
        );
      end
    end

    assign pin_oe_o[p*DATA_W +: DATA_W]    = grp_q[G_DIR][p];
    assign pin_out_o[p*DATA_W +: DATA_W]   = grp_q[G_OUT][p] & grp_q[G_DIR][p];
    assign irq_flag_o[p*DATA_W +: DATA_W]  = grp_q[G_FLAG][p];
    assign irq_en_o[p*DATA_W +: DATA_W]    = grp_q[G_EN][p];
    assign irq_pol_o[p*DATA_W +: DATA_W]   = grp_q[G_POL][p];
    assign irq_type_o[p*DATA_W +: DATA_W]  = grp_q[G_TYPE][p];
    assign irq_async_o[p*DATA_W +: DATA_W] = grp_q[G_ASYN][p];
  end

  always_comb begin
    rd_val = '0;
    if (dec.hit) begin
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
        for (int g = 0; g < int'(NUM_GRP); g++) begin
          if (32'(dec.port) == p && 32'(dec.grp) == g) rd_val = grp_q[g][p];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      bus_rvalid_o <= bus_re_i;
      if (bus_re_i) bus_rdata_o <= rd_val;
    end
  end
endmodule

// File: rtl/gpio_rb_chk.sv
module gpio_rb_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [11:0]                 bus_addr_i,
  input logic                        bus_we_i,
  input logic [DATA_W-1:0]           bus_wdata_i,
  input logic                        bus_re_i,
  input logic [DATA_W-1:0]           bus_rdata_o,
  input logic                        bus_rvalid_o,
  input logic [NUM_PORTS*DATA_W-1:0] pin_oe_o,
  input logic [NUM_PORTS*DATA_W-1:0] irq_flag_o,
  input logic [NUM_PORTS*DATA_W-1:0] irq_en_o
);
  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_i |=> bus_rvalid_o); // R5
  AST_RSVD_GRP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && bus_addr_i[11]) |=> (bus_rdata_o == '0)); // R10
  AST_DIR_SET_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i[11:2] == 10'h081)
      |=> ((pin_oe_o[DATA_W-1:0] & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R3
  AST_DIR_CLR_ANDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i[11:2] == 10'h082)
      |=> ((pin_oe_o[DATA_W-1:0] & $past(bus_wdata_i)) == '0)); // R3
  AST_EN_TGL_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i[11:2] == 10'h103)
      |=> (irq_en_o[DATA_W-1:0] == ($past(irq_en_o[DATA_W-1:0]) ^ $past(bus_wdata_i)))); // R3
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |=> ($stable(pin_oe_o) && $stable(irq_en_o))); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |=> ((irq_flag_o & $past(irq_flag_o)) == $past(irq_flag_o))); // R9
endmodule

bind gpio_regbank gpio_rb_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_addr_i   (bus_addr_i),
  .bus_we_i     (bus_we_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_re_i     (bus_re_i),
  .bus_rdata_o  (bus_rdata_o),
  .bus_rvalid_o (bus_rvalid_o),
  .pin_oe_o     (pin_oe_o),
  .irq_flag_o   (irq_flag_o),
  .irq_en_o     (irq_en_o)
);

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam int VW = NP * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_re = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [VW-1:0] pin_in = '0;
  logic [VW-1:0] flag_set = '0;
  logic [VW-1:0] pin_out, pin_oe, irq_flag, irq_en, irq_pol, irq_type, irq_async;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #10 clk = ~clk;

  gpio_regbank #(.NUM_PORTS(NP), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_we_i(bus_we), .bus_wdata_i(bus_wdata),
    .bus_re_i(bus_re), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe),
    .flag_set_i(flag_set), .irq_flag_o(irq_flag),
    .irq_en_o(irq_en), .irq_pol_o(irq_pol), .irq_type_o(irq_type), .irq_async_o(irq_async)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R5 unexpected read data act=%h exp=none", bus_rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_err++;
          $display("FAIL %s read act=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [VW-1:0] act, input logic [VW-1:0] exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s port act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic rdwr(input logic [11:0] a, input logic [DW-1:0] d, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    bus_re = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pin_oe, '0, "R1");
    chk(pin_out | irq_en | irq_pol | irq_type | irq_async | irq_flag, '0, "R1");
    rd(12'h100, 32'h0, "R1");

    // R6 direction gating
    wr(12'h210, 32'h0000FFFF);
    wr(12'h110, 32'h12345678);
    chk(pin_oe, {64'h0, 32'h0000FFFF, 32'h0}, "R6");
    chk(pin_out, {64'h0, 32'h00005678, 32'h0}, "R6");

    // R4 alias reads
    rd(12'h214, 32'h0000FFFF, "R4");
    rd(12'h11C, 32'h12345678, "R4");

    // R3 set / clear / toggle chain
    wr(12'h114, 32'hF0000000);
    rd(12'h110, 32'hF2345678, "R3");
    wr(12'h118, 32'h00000078);
    rd(12'h110, 32'hF2345600, "R3");
    wr(12'h11C, 32'hFF0000FF);
    rd(12'h110, 32'h0D3456FF, "R3");
    // R2 low address bits ignored
    rd(12'h113, 32'h0D3456FF, "R2");

    // R11 configuration exports
    wr(12'h420, 32'hA5A5A5A5);
    wr(12'h42C, 32'hFFFF0000);
    chk(irq_en, {32'h0, 32'h5A5AA5A5, 64'h0}, "R11");
    wr(12'h534, 32'h00000001);
    wr(12'h604, 32'h80000000);
    wr(12'h730, 32'h0000000C);
    chk(irq_pol, {32'h1, 96'h0}, "R11");
    chk(irq_type, {96'h0, 32'h80000000}, "R11");
    chk(irq_async, {32'hC, 96'h0}, "R11");

    // R5 read and write same cycle returns old value
    rdwr(12'h110, 32'hCAFEF00D, 32'h0D3456FF, "R5");
    rd(12'h110, 32'hCAFEF00D, "R5");

    // R7 synchronizer depth, back-to-back reads of port 2 input
    @(negedge clk);
    pin_in[95:64] = 32'hDEADBEEF;
    bus_re = 1'b1; bus_addr = 12'h020;
    exp_q.push_back(32'h0); tag_q.push_back("R7");
    @(negedge clk);
    exp_q.push_back(32'h0); tag_q.push_back("R7");
    @(negedge clk);
    exp_q.push_back(32'hDEADBEEF); tag_q.push_back("R7");
    @(negedge clk);
    bus_re = 1'b0;

    // R8 input group single word, read only
    rd(12'h024, 32'h0, "R8");
    wr(12'h020, 32'h0);
    rd(12'h020, 32'hDEADBEEF, "R8");

    // R9 flags
    @(negedge clk);
    flag_set[63:32] = 32'h11;
    @(negedge clk);
    flag_set = '0;
    chk(irq_flag, {64'h0, 32'h11, 32'h0}, "R9");
    rd(12'h310, 32'h11, "R9");
    wr(12'h310, 32'h1);
    rd(12'h310, 32'h10, "R9");
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 12'h310; bus_wdata = 32'h10;
    flag_set[63:32] = 32'h10;
    @(negedge clk);
    bus_we = 1'b0; flag_set = '0;
    rd(12'h310, 32'h10, "R9");
    wr(12'h314, 32'h10);
    rd(12'h310, 32'h10, "R8");
    rd(12'h318, 32'h0, "R8");
    wr(12'h310, 32'h10);
    rd(12'h310, 32'h0, "R9");

    // R10 reserved groups and unimplemented ports
    wr(12'h800, 32'hFFFFFFFF);
    wr(12'h240, 32'hFFFFFFFF);
    wr(12'hF14, 32'hFFFFFFFF);
    chk(pin_oe, {64'h0, 32'h0000FFFF, 32'h0}, "R10");
    chk(irq_en, {32'h0, 32'h5A5AA5A5, 64'h0}, "R10");
    rd(12'h800, 32'h0, "R10");
    rd(12'h240, 32'h0, "R10");
    rd(12'hF1C, 32'h0, "R10");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R5 missing reads act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule